// File: doc/BRIEF.md
# String Repeat Address Controller

This block steps a repeated string operation one element at a time on a byte or word data path. It holds a source pointer, a destination pointer and a repetition counter. A direction flag, changed only by its own set and clear commands, chooses whether both pointers count up or down. When started, the block asks the memory side for one element transfer. When the acknowledge comes back, it moves both pointers by the element size and counts the repetition down. It then decides whether to go on or to finish.

Finishing depends on the repeat mode chosen at start. Plain repeat runs until the counter reaches zero. The two conditional modes also stop early, depending on a compare-equal result that the datapath supplies with each acknowledge. A counter that is already zero at start finishes at once, with no transfer. Segment formation, instruction decode and the memory itself sit outside this block. The pointer and counter values are outputs, so the surrounding logic uses them directly as element addresses and as the remaining count.

Top module: `strep_ctrl`

## Requirements
- R1: After reset both pointers and the counter are zero, the direction flag is 0, and mem_req, busy and done are low.
- R2: A load pulse while idle writes load_src, load_dst and load_cnt into the source pointer, destination pointer and counter at the next edge. A load pulse while busy changes none of them.
- R3: dir_set makes the direction flag 1 and dir_clr makes it 0, with clear winning if both are high. Both commands are ignored while busy.
- R4: Each acknowledged element moves both pointers by the stride, modulo 2^IDX_W. The stride is 2 when elem_word was 1 at start and 1 otherwise. The pointers move upward when the direction flag is 0 and downward when it is 1.
- R5: Each acknowledged element lowers the counter by one. In plain mode (rep_mode 2'b00, and also 2'b11) the operation ends after the element that brings the counter to zero.
- R6: In repeat-while-equal mode (rep_mode 2'b01), the operation also ends after an element acknowledged with cmp_eq low.
- R7: In repeat-while-not-equal mode (rep_mode 2'b10), the operation also ends after an element acknowledged with cmp_eq high.
- R8: A start with the counter at zero issues no request, and done is high in the cycle after the start edge.
- R9: mem_req stays high with both pointers steady until mem_ack is seen. After each acknowledge that does not end the operation, mem_req is low for exactly one cycle before the next element is requested.
- R10: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse in the cycle after the final acknowledge. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_set | input | 1 | Command: direction flag to 1 (downward) |
| dir_clr | input | 1 | Command: direction flag to 0 (upward) |
| load | input | 1 | Write pointer and counter values while idle |
| load_src | input | IDX_W | Source pointer value to load |
| load_dst | input | IDX_W | Destination pointer value to load |
| load_cnt | input | CNT_W | Repetition count to load |
| start | input | 1 | Begin a repeated operation |
| rep_mode | input | 2 | 00/11 plain, 01 while equal, 10 while not equal |
| elem_word | input | 1 | 1: word elements (stride 2), 0: bytes (stride 1) |
| cmp_eq | input | 1 | Compare-equal result, sampled with mem_ack |
| mem_ack | input | 1 | Memory side has completed the current element |
| mem_req | output | 1 | Element transfer request |
| src_idx | output | IDX_W | Current source pointer |
| dst_idx | output | IDX_W | Current destination pointer |
| count | output | CNT_W | Remaining repetitions |
| dir_flag | output | 1 | Direction flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a command or load that arrives in the middle of an operation, while a request is still waiting for its acknowledge. The bench handles this by holding back the acknowledge for a random number of cycles. In some operations it injects a load, a start and a direction flip during that wait. It then checks the pointer values at the next request and the direction flag afterwards. The early exits of the two conditional modes are driven by directed cmp_eq patterns that flip on a chosen element. The downward word case starts near zero, so the pointers wrap.

// File: rtl/strep_pkg.sv
// Shared types for the string repeat address controller.
package strep_pkg;

    // Repeat mode code as presented on rep_mode.
    typedef enum logic [1:0] {
        REP_PLAIN     = 2'b00,
        REP_WHILE_EQ  = 2'b01,
        REP_WHILE_NE  = 2'b10,
        REP_PLAIN_ALT = 2'b11
    } rep_mode_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_XFER = 2'b01,
        ST_GAP  = 2'b10,
        ST_FIN  = 2'b11
    } seq_state_e;

endpackage

// File: rtl/strep_dirflag.sv
// Direction flag register.
// Holds the pointer stepping direction (1 = downward). It is changed only by the
// set and clear commands, and only while unlocked. Clear has priority.
// Assumes lock is high for the whole of a running operation.
module strep_dirflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic lock,
    output logic dir
);

    // Purpose: apply set/clear commands while not locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= 1'b0;
        end else if (!lock) begin
            if (clr_cmd) begin
                dir <= 1'b0;
            end else if (set_cmd) begin
                dir <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/strep_index.sv
// One string pointer register.
// Loads a new value on load. On step it moves by 1 (byte) or 2 (word),
// downward when dec is high and upward otherwise, wrapping modulo 2^W.
// Assumes load and step are never high together (load is idle-only).
module strep_index #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         dec,
    input  logic         word,
    output logic [W-1:0] idx
);

    logic [W-1:0] stride;
    logic [W-1:0] idx_next;

    // Purpose: element size to pointer stride (needs W >= 2).
    always_comb begin
        stride = {{(W-2){1'b0}}, word, ~word};
    end

    // Purpose: stepped pointer value in the selected direction.
    always_comb begin
        idx_next = dec ? (idx - stride) : (idx + stride);
    end

    // Purpose: pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end else if (step) begin
            idx <= idx_next;
        end
    end

endmodule

// File: rtl/strep_count.sv
// Repetition counter.
// Loads on load and counts down by one on dec_en. It flags zero and one
// so the sequencer can tell ahead of the edge that an element is the last.
// Assumes dec_en is never raised while the counter is zero.
module strep_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] cnt,
    output logic         is_zero,
    output logic         is_one
);

    localparam logic [W-1:0] CNT_ONE = W'(1);

    // Purpose: counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec_en) begin
            cnt <= cnt - CNT_ONE;
        end
    end

    // Purpose: decode the zero and last-element conditions.
    always_comb begin
        is_zero = (cnt == '0);
        is_one  = (cnt == CNT_ONE);
    end

    // The counter never counts below zero.
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> !is_zero);

endmodule

// File: rtl/strep_seq.sv
// Operation sequencer.
// Idle -> transfer (request high until ack) -> gap (one cycle) -> transfer ...
// and -> finish (done for one cycle) -> idle. It latches the repeat mode and the
// element size at start. After each ack it decides whether to end the operation,
// using the counter and the compare-equal result.
// Assumes cmp_eq is valid in the cycle mem_ack is high.
module strep_seq
    import strep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] mode_in,
    input  logic       word_in,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    input  logic       cmp_eq,
    input  logic       mem_ack,
    output logic       mem_req,
    output logic       step,
    output logic       busy,
    output logic       done,
    output logic       word_q
);

    seq_state_e state_q, state_d;
    rep_mode_e  mode_q;
    logic       stop_elem;

    // Purpose: decide whether the element being acknowledged is the last one.
    always_comb begin
        stop_elem = cnt_one
                  | ((mode_q == REP_WHILE_EQ) & ~cmp_eq)
                  | ((mode_q == REP_WHILE_NE) &  cmp_eq);
    end

    // Purpose: next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = cnt_zero  ? ST_FIN : ST_XFER;
            ST_XFER: if (mem_ack) state_d = stop_elem ? ST_FIN : ST_GAP;
            ST_GAP:  state_d = ST_XFER;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register and start-time latching of mode and size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= REP_PLAIN;
            word_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                mode_q <= rep_mode_e'(mode_in);
                word_q <= word_in;
            end
        end
    end

    // Purpose: decode outputs from the state.
    always_comb begin
        mem_req = (state_q == ST_XFER);
        step    = mem_req & mem_ack;
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FIN);
    end

    // A mismatch in while-equal mode ends the operation.
    assert_eq_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q == REP_WHILE_EQ && !cmp_eq) |=> done);

    // A match in while-not-equal mode ends the operation.
    assert_ne_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q == REP_WHILE_NE && cmp_eq) |=> done);

    // The element that empties the counter ends the operation.
    assert_last_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_one) |=> done);

endmodule

// File: rtl/strep_ctrl.sv
// String repeat address controller (top).
// Holds the source and destination pointers, the repetition counter and the
// direction flag. It sequences one memory request per element until the
// repeat mode's exit condition holds. Loads and direction commands are
// accepted only while idle.
// Assumes the memory side holds mem_ack for one cycle per element.
module strep_ctrl #(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_set,
    input  logic             dir_clr,
    input  logic             load,
    input  logic [IDX_W-1:0] load_src,
    input  logic [IDX_W-1:0] load_dst,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             start,
    input  logic [1:0]       rep_mode,
    input  logic             elem_word,
    input  logic             cmp_eq,
    input  logic             mem_ack,
    output logic             mem_req,
    output logic [IDX_W-1:0] src_idx,
    output logic [IDX_W-1:0] dst_idx,
    output logic [CNT_W-1:0] count,
    output logic             dir_flag,
    output logic             busy,
    output logic             done
);

    localparam int N_PTR = 2;

    logic             load_ok;
    logic             step;
    logic             word_q;
    logic             cnt_zero;
    logic             cnt_one;
    logic [IDX_W-1:0] ptr_load [N_PTR];
    logic [IDX_W-1:0] ptr_val  [N_PTR];

    // Purpose: loads are honoured only while idle.
    always_comb begin
        load_ok = load & ~busy;
    end

    // Purpose: route the load values to the pointer array and the array to the ports.
    always_comb begin
        ptr_load[0] = load_src;
        ptr_load[1] = load_dst;
        src_idx     = ptr_val[0];
        dst_idx     = ptr_val[1];
    end

    strep_dirflag u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (dir_set),
        .clr_cmd (dir_clr),
        .lock    (busy),
        .dir     (dir_flag)
    );

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        strep_index #(.W(IDX_W)) u_idx (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_ok),
            .load_val (ptr_load[g]),
            .step     (step),
            .dec      (dir_flag),
            .word     (word_q),
            .idx      (ptr_val[g])
        );
    end

    strep_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (load_cnt),
        .dec_en   (step),
        .cnt      (count),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    strep_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_in  (rep_mode),
        .word_in  (elem_word),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .cmp_eq   (cmp_eq),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .step     (step),
        .busy     (busy),
        .done     (done),
        .word_q   (word_q)
    );

    // A waiting request holds and keeps its addresses.
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(src_idx) && $stable(dst_idx)));

    // An acknowledge always drops the request for at least one cycle.
    assert_req_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // The counter drops by one per acknowledged element.
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (count == $past(count) - CNT_W'(1)));

    // The source pointer moves by the stride in the flag's direction.
    assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=>
            (src_idx == ($past(dir_flag)
                ? $past(src_idx) - ($past(word_q) ? IDX_W'(2) : IDX_W'(1))
                : $past(src_idx) + ($past(word_q) ? IDX_W'(2) : IDX_W'(1)))));

    // The direction flag cannot change during an operation.
    assert_dir_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dir_flag));

    // An empty count finishes at once without a request.
    assert_zero_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == '0) |=> (done && !mem_req));

    // done lasts one cycle and returns to idle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // Loads during an operation leave the counter alone, apart from stepping.
    assert_load_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |=> $stable(count));

endmodule

// File: tb/tb_strep_ctrl.sv
`timescale 1ns/1ps
// Bench for strep_ctrl: directed corner cases plus seeded random operations,
// compared against a bench model of pointers, counter and exit rules.
module tb_strep_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_set = 1'b0, dir_clr = 1'b0, load = 1'b0;
    logic [15:0] load_src = '0, load_dst = '0, load_cnt = '0;
    logic        start = 1'b0;
    logic [1:0]  rep_mode = 2'b00;
    logic        elem_word = 1'b0, cmp_eq = 1'b0, mem_ack = 1'b0;
    logic        mem_req, dir_flag, busy, done;
    logic [15:0] src_idx, dst_idx, count;

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] m_src = '0, m_dst = '0, m_cnt = '0;
    logic        m_dir = 1'b0;

    always #2.5 clk = ~clk;

    strep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dir_set(dir_set), .dir_clr(dir_clr),
        .load(load), .load_src(load_src), .load_dst(load_dst), .load_cnt(load_cnt),
        .start(start), .rep_mode(rep_mode), .elem_word(elem_word), .cmp_eq(cmp_eq),
        .mem_ack(mem_ack), .mem_req(mem_req), .src_idx(src_idx), .dst_idx(dst_idx),
        .count(count), .dir_flag(dir_flag), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_step(input logic [15:0] v, input logic dn, input logic w);
        logic [15:0] s;
        s = w ? 16'd2 : 16'd1;
        return dn ? v - s : v + s;
    endfunction

    function automatic logic f_stop(input logic [1:0] md, input logic [15:0] cnt_after, input logic eq);
        if (cnt_after == 16'd0) return 1'b1;
        if (md == 2'b01 && !eq) return 1'b1;
        if (md == 2'b10 && eq)  return 1'b1;
        return 1'b0;
    endfunction

    function automatic string f_tag(input logic [1:0] md);
        if (md == 2'b01) return "R6";
        if (md == 2'b10) return "R7";
        return "R5";
    endfunction

    task automatic do_load(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
        @(negedge clk);
        load = 1'b1; load_src = s; load_dst = d; load_cnt = c;
        @(negedge clk);
        load = 1'b0;
        m_src = s; m_dst = d; m_cnt = c;
        chk("R2 src", src_idx, s);
        chk("R2 dst", dst_idx, d);
        chk("R2 cnt", count, c);
    endtask

    task automatic do_dir(input logic v);
        @(negedge clk);
        dir_set = v; dir_clr = ~v;
        @(negedge clk);
        dir_set = 1'b0; dir_clr = 1'b0;
        m_dir = v;
        chk("R3 dir", dir_flag, v);
    endtask

    // stop_at >= 0 forces continuing compare values before that element and a stopping one on it.
    task automatic run_op(input logic [1:0] md, input logic w, input int stop_at, input bit poke);
        bit stop;
        int k;
        int wt;
        logic eq;
        @(negedge clk);
        start = 1'b1; rep_mode = md; elem_word = w;
        @(negedge clk);
        start = 1'b0;
        if (m_cnt == 16'd0) begin
            chk("R8 done", done, 1'b1);
            chk("R8 req", mem_req, 1'b0);
            @(negedge clk);
            chk("R10 done pulse", done, 1'b0);
            chk("R10 idle", busy, 1'b0);
            return;
        end
        stop = 1'b0;
        k = 0;
        while (!stop) begin
            chk("R9 req", mem_req, 1'b1);
            chk("R10 busy", busy, 1'b1);
            chk("R4 src", src_idx, m_src);
            chk("R4 dst", dst_idx, m_dst);
            wt = $urandom_range(0, 3);
            if (poke && k == 0) wt = wt + 1;
            for (int i = 0; i < wt; i++) begin
                if (poke && k == 0 && i == 0) begin
                    load = 1'b1; load_src = ~m_src; load_dst = ~m_dst; load_cnt = 16'h7777;
                    dir_set = ~m_dir; dir_clr = m_dir; start = 1'b1;
                end
                @(negedge clk);
                load = 1'b0; dir_set = 1'b0; dir_clr = 1'b0; start = 1'b0;
                chk("R9 req held", mem_req, 1'b1);
                chk("R2 cnt unchanged while busy", count, m_cnt);
                chk("R2 src unchanged while busy", src_idx, m_src);
            end
            if (stop_at >= 0) begin
                if (md == 2'b01)      eq = (k != stop_at);
                else if (md == 2'b10) eq = (k == stop_at);
                else                  eq = 1'($urandom_range(0, 1));
            end else begin
                if (md == 2'b01)      eq = ($urandom_range(0, 4) != 0);
                else if (md == 2'b10) eq = ($urandom_range(0, 4) == 0);
                else                  eq = 1'($urandom_range(0, 1));
            end
            mem_ack = 1'b1; cmp_eq = eq;
            @(negedge clk);
            mem_ack = 1'b0; cmp_eq = 1'b0;
            m_src = f_step(m_src, m_dir, w);
            m_dst = f_step(m_dst, m_dir, w);
            m_cnt = m_cnt - 16'd1;
            stop = f_stop(md, m_cnt, eq);
            chk("R5 count", count, m_cnt);
            chk("R3 dir locked", dir_flag, m_dir);
            if (stop) begin
                chk({f_tag(md), " exit done"}, done, 1'b1);
                chk("R10 no req at done", mem_req, 1'b0);
                @(negedge clk);
                chk("R10 done pulse", done, 1'b0);
                chk("R10 idle", busy, 1'b0);
            end else begin
                chk({f_tag(md), " continue"}, done, 1'b0);
                chk("R9 gap", mem_req, 1'b0);
                @(negedge clk);
            end
            k++;
        end
        chk("R4 final src", src_idx, m_src);
        chk("R4 final dst", dst_idx, m_dst);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 src", src_idx, 16'h0);
        chk("R1 dst", dst_idx, 16'h0);
        chk("R1 cnt", count, 16'h0);
        chk("R1 dir", dir_flag, 1'b0);
        chk("R1 req", mem_req, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        rst_n = 1'b1;

        // Plain byte copy upward.
        do_dir(1'b0);
        do_load(16'h0010, 16'h0200, 16'd4);
        run_op(2'b00, 1'b0, -1, 1'b0);
        // Empty count.
        do_load(16'h1234, 16'h5678, 16'd0);
        run_op(2'b01, 1'b1, -1, 1'b0);
        chk("R8 src untouched", src_idx, 16'h1234);
        // Conditional exits on the third element.
        do_load(16'h0100, 16'h0300, 16'd10);
        run_op(2'b01, 1'b0, 2, 1'b0);
        chk("R6 early count", count, 16'd7);
        do_load(16'h0100, 16'h0300, 16'd10);
        run_op(2'b10, 1'b1, 2, 1'b0);
        chk("R7 early count", count, 16'd7);
        // Conditional mode running to count exhaustion.
        do_load(16'h0040, 16'h0080, 16'd3);
        run_op(2'b01, 1'b1, 99, 1'b0);
        // Downward word with wrap, plus mid-operation pokes.
        do_dir(1'b1);
        do_load(16'h0001, 16'h0000, 16'd3);
        run_op(2'b11, 1'b1, -1, 1'b1);
        // Clear wins over set.
        @(negedge clk);
        dir_set = 1'b1; dir_clr = 1'b1;
        @(negedge clk);
        dir_set = 1'b0; dir_clr = 1'b0; m_dir = 1'b0;
        chk("R3 clear priority", dir_flag, 1'b0);

        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(0, 2) == 0) do_dir(1'($urandom_range(0, 1)));
            do_load(16'($urandom), 16'($urandom), 16'($urandom_range(0, 12)));
            run_op(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), -1,
                   ($urandom_range(0, 3) == 0));
        end
        finish_run();
    end

endmodule